// File: doc/BRIEF.md
# Paged Memory Protection Gate

This block sits in front of a small paged non-volatile user memory and rules on every access to it. The memory is a set of 32-byte pages that are written one 4-byte segment at a time, and the segments are grouped into protection blocks. Each protection block carries four sticky flags:

- hide-from-reads
- freeze
- clear-only (bits may only fall from 1 to 0)
- needs-authentication

A request is a read, a plain write, an authenticated write or a flag update. It takes one clock edge. The decision, together with any change to memory or flags, is made on that edge, and the response appears on the next cycle.

Message authentication is computed elsewhere. A single input, `mac_ok`, reports whether the code for the current authenticated write was verified. A separate internal read port lets neighbouring logic use the stored contents, for example as secret material, whatever the hide flag says. The array is held in registers, and protection block size is a parameter: half a page or two pages.

Top module: `blkprot_gate`

## Requirements
- R1: A request accepted with `req_valid` high gives `rsp_valid` high in the next cycle, and only then. On an unprotected segment, a plain write (op 1) stores `req_data` and returns code 0 with the stored value in `rsp_data`. A later read (op 0) returns code 0 and that value.
- R2: A read of a segment whose block has the hide flag (flag bit 3) set returns code 1 and `rsp_data` = 0. The internal port `int_seg`/`int_data` still returns the stored value.
- R3: When a block's freeze flag (bit 2) is set, every write to it returns code 2, whether plain or authenticated and whatever `mac_ok` is, and the stored data does not change. This check takes precedence over the authentication check.
- R4: When a block's clear-only flag (bit 1) is set, an accepted write stores the old data ANDed with `req_data`. The response returns that stored value.
- R5: When a block's needs-authentication flag (bit 0) is set, a plain write returns code 3. An authenticated write (op 2) with `mac_ok` low also returns code 3. An authenticated write with `mac_ok` high is accepted.
- R6: An authenticated write to a block without the needs-authentication flag is accepted when `mac_ok` is high. When `mac_ok` is low it returns code 3 and leaves the data unchanged.
- R7: A flag update (op 3) ORs `req_prot` into the flags of the block that holds `req_seg`, so a set flag is never cleared. It returns code 0 with the resulting flags in `rsp_data[3:0]`.
- R8: After reset every segment reads as 0, every block's flags are 0, and `rsp_valid` is low.
- R9: The flags combine. When clear-only and needs-authentication are both set, a plain write gets code 3, and an authenticated write with `mac_ok` high stores old AND new.
- R10: The block number is the segment number divided by the segments per block. With the default half-page blocks, that is 4 segments per block, so segments 3 and 4 fall in different blocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request present this cycle |
| req_op | input | 2 | 0 read, 1 plain write, 2 authenticated write, 3 flag update |
| req_seg | input | SEG_AW (5) | Segment number (page times segments per page plus segment) |
| req_data | input | SEG_W (32) | New segment data for writes |
| req_prot | input | 4 | Flags to set: bit 3 hide, bit 2 freeze, bit 1 clear-only, bit 0 needs-authentication |
| mac_ok | input | 1 | Authentication code verified for this authenticated write |
| int_seg | input | SEG_AW (5) | Internal read segment number |
| int_data | output | SEG_W (32) | Internal read data, ignores the hide flag |
| rsp_valid | output | 1 | Response valid |
| rsp_code | output | 2 | 0 ok, 1 read hidden, 2 frozen, 3 authentication required |
| rsp_data | output | SEG_W (32) | Read data, stored value, resulting flags, or 0 on failure |

## Verification
The properties assume that `req_op`, `req_seg`, `req_data`, `req_prot` and `mac_ok` are only meaningful in a cycle where `req_valid` is high. They also assume that `mac_ok` only matters for authenticated writes. The stimulus drives each request for exactly one cycle on the falling edge, with an idle cycle in between, so every response can be sampled before the next request. Segment numbers stay within the array, and flags are only ever added.

// File: rtl/blkprot_pkg.sv
package blkprot_pkg;
  localparam int PROT_W = 4;
  localparam int F_HIDE   = 3;
  localparam int F_FREEZE = 2;
  localparam int F_CLRONL = 1;
  localparam int F_NEEDMAC = 0;

  typedef enum logic [1:0] {
    OP_READ  = 2'd0,
    OP_WRITE = 2'd1,
    OP_AUTH  = 2'd2,
    OP_PROT  = 2'd3
  } op_e;

  typedef enum logic [1:0] {
    RC_OK       = 2'd0,
    RC_HIDDEN   = 2'd1,
    RC_FROZEN   = 2'd2,
    RC_NEEDAUTH = 2'd3
  } rc_e;

  // Verdict for a write request given block flags; freeze dominates.
  function automatic rc_e write_verdict(input logic [PROT_W-1:0] flags,
                                        input logic is_auth,
                                        input logic mac_good);
    if (flags[F_FREEZE])                        return RC_FROZEN;
    if (!is_auth && flags[F_NEEDMAC])           return RC_NEEDAUTH;
    if (is_auth && !mac_good)                   return RC_NEEDAUTH;
    return RC_OK;
  endfunction
endpackage

// File: rtl/blkprot_tags.sv
module blkprot_tags
  import blkprot_pkg::*;
#(
  parameter int NUM_BLK = 8,
  localparam int BLK_W = (NUM_BLK > 1) ? $clog2(NUM_BLK) : 1
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [BLK_W-1:0]          rd_blk,
  output logic [PROT_W-1:0]         rd_flags,
  input  logic                      upd_en,
  input  logic [BLK_W-1:0]          upd_blk,
  input  logic [PROT_W-1:0]         upd_bits,
  output logic [NUM_BLK*PROT_W-1:0] flags_flat
);
  logic [PROT_W-1:0] flags_q [NUM_BLK];

  for (genvar b = 0; b < NUM_BLK; b++) begin : g_blk
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        flags_q[b] <= '0;
      else if (upd_en && upd_blk == BLK_W'(b))
        flags_q[b] <= flags_q[b] | upd_bits;
    end
    assign flags_flat[b*PROT_W +: PROT_W] = flags_q[b];
  end

  assign rd_flags = flags_q[rd_blk];
endmodule

// File: rtl/blkprot_store.sv
module blkprot_store #(
  parameter int NUM_SEG = 32,
  parameter int SEG_W   = 32,
  localparam int SEG_AW = $clog2(NUM_SEG)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [SEG_AW-1:0] rd_seg,
  output logic [SEG_W-1:0]  rd_data,
  input  logic [SEG_AW-1:0] int_seg,
  output logic [SEG_W-1:0]  int_data,
  input  logic              wr_en,
  input  logic [SEG_AW-1:0] wr_seg,
  input  logic [SEG_W-1:0]  wr_data
);
  logic [SEG_W-1:0] cell_q [NUM_SEG];

  for (genvar s = 0; s < NUM_SEG; s++) begin : g_seg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        cell_q[s] <= '0;
      else if (wr_en && wr_seg == SEG_AW'(s))
        cell_q[s] <= wr_data;
    end
  end

  assign rd_data  = cell_q[rd_seg];
  assign int_data = cell_q[int_seg];
endmodule

// File: rtl/blkprot_judge.sv
module blkprot_judge
  import blkprot_pkg::*;
#(
  parameter int SEG_W = 32
) (
  input  logic [1:0]        op,
  input  logic [PROT_W-1:0] flags,
  input  logic              mac_ok,
  input  logic [SEG_W-1:0]  old_data,
  input  logic [SEG_W-1:0]  new_data,
  output rc_e               code,
  output logic              rd_ok,
  output logic              wr_ok,
  output logic [SEG_W-1:0]  wr_value
);
  // Clear-only blocks keep a 0 wherever the old data had one.
  function automatic logic [SEG_W-1:0] merge_seg(input logic clr_only,
                                                 input logic [SEG_W-1:0] prev,
                                                 input logic [SEG_W-1:0] next);
    return clr_only ? (prev & next) : next;
  endfunction

  always_comb begin
    code  = RC_OK;
    rd_ok = 1'b0;
    wr_ok = 1'b0;
    unique case (op_e'(op))
      OP_READ: begin
        if (flags[F_HIDE]) code = RC_HIDDEN;
        else               rd_ok = 1'b1;
      end
      OP_WRITE, OP_AUTH: begin
        code  = write_verdict(flags, op == OP_AUTH, mac_ok);
        wr_ok = (code == RC_OK);
      end
      default: code = RC_OK;
    endcase
  end

  assign wr_value = merge_seg(flags[F_CLRONL], old_data, new_data);
endmodule

// File: rtl/blkprot_gate.sv
module blkprot_gate
  import blkprot_pkg::*;
#(
  parameter int PAGES            = 4,
  parameter int PAGE_BYTES       = 32,
  parameter int SEG_BYTES        = 4,
  parameter bit HALF_PAGE_BLOCKS = 1'b1,
  localparam int SEG_W          = 8 * SEG_BYTES,
  localparam int SEGS_PER_PAGE  = PAGE_BYTES / SEG_BYTES,
  localparam int NUM_SEG        = PAGES * SEGS_PER_PAGE,
  localparam int SEG_AW         = $clog2(NUM_SEG)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [1:0]        req_op,
  input  logic [SEG_AW-1:0] req_seg,
  input  logic [SEG_W-1:0]  req_data,
  input  logic [3:0]        req_prot,
  input  logic              mac_ok,
  input  logic [SEG_AW-1:0] int_seg,
  output logic [SEG_W-1:0]  int_data,
  output logic              rsp_valid,
  output logic [1:0]        rsp_code,
  output logic [SEG_W-1:0]  rsp_data
);
  localparam int BLK_SEGS = HALF_PAGE_BLOCKS ? (SEGS_PER_PAGE / 2) : (2 * SEGS_PER_PAGE);
  localparam int NUM_BLK  = NUM_SEG / BLK_SEGS;
  localparam int BLK_SH   = $clog2(BLK_SEGS);
  localparam int BLK_W    = (NUM_BLK > 1) ? $clog2(NUM_BLK) : 1;

  // Named internal events, observed by the bound checker.
  logic [BLK_W-1:0]          req_blk;
  logic [PROT_W-1:0]         cur_prot;
  logic [NUM_BLK*PROT_W-1:0] prot_flat;
  logic [SEG_W-1:0]          old_data;
  logic [SEG_W-1:0]          wr_value;
  logic                      rd_ok;
  logic                      wr_ok;
  logic                      wr_en;
  logic                      upd_en;
  logic [PROT_W-1:0]         prot_after;
  rc_e                       code;

  assign req_blk    = BLK_W'(req_seg >> BLK_SH);
  assign wr_en      = req_valid && wr_ok;
  assign upd_en     = req_valid && (req_op == OP_PROT);
  assign prot_after = cur_prot | req_prot;

  blkprot_tags #(.NUM_BLK(NUM_BLK)) u_tags (
    .clk       (clk),
    .rst_n     (rst_n),
    .rd_blk    (req_blk),
    .rd_flags  (cur_prot),
    .upd_en    (upd_en),
    .upd_blk   (req_blk),
    .upd_bits  (req_prot),
    .flags_flat(prot_flat)
  );

  blkprot_store #(.NUM_SEG(NUM_SEG), .SEG_W(SEG_W)) u_store (
    .clk     (clk),
    .rst_n   (rst_n),
    .rd_seg  (req_seg),
    .rd_data (old_data),
    .int_seg (int_seg),
    .int_data(int_data),
    .wr_en   (wr_en),
    .wr_seg  (req_seg),
    .wr_data (wr_value)
  );

  blkprot_judge #(.SEG_W(SEG_W)) u_judge (
    .op      (req_op),
    .flags   (cur_prot),
    .mac_ok  (mac_ok),
    .old_data(old_data),
    .new_data(req_data),
    .code    (code),
    .rd_ok   (rd_ok),
    .wr_ok   (wr_ok),
    .wr_value(wr_value)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_code  <= RC_OK;
      rsp_data  <= '0;
    end else begin
      rsp_valid <= req_valid;
      if (req_valid) begin
        rsp_code <= code;
        if (rd_ok)       rsp_data <= old_data;
        else if (wr_ok)  rsp_data <= wr_value;
        else if (upd_en) rsp_data <= SEG_W'(prot_after);
        else             rsp_data <= '0;
      end else begin
        rsp_code <= RC_OK;
        rsp_data <= '0;
      end
    end
  end
endmodule

// File: rtl/blkprot_chk.sv
module blkprot_chk #(
  parameter int NUM_BLK = 8,
  parameter int SEG_W   = 32
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 req_valid,
  input logic [1:0]           req_op,
  input logic                 mac_ok,
  input logic                 rsp_valid,
  input logic [1:0]           rsp_code,
  input logic [SEG_W-1:0]     rsp_data,
  input logic [3:0]           cur_prot,
  input logic                 wr_en,
  input logic [SEG_W-1:0]     wr_value,
  input logic [SEG_W-1:0]     old_data,
  input logic [NUM_BLK*4-1:0] prot_flat
);
  AST_RSP_FOLLOWS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> rsp_valid == $past(req_valid)); // R1

  AST_HIDDEN_READ: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_op == 2'd0 && cur_prot[3] |=> rsp_code == 2'd1 && rsp_data == '0); // R2

  AST_FROZEN_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && (req_op == 2'd1 || req_op == 2'd2) && cur_prot[2] |-> !wr_en); // R3

  AST_CLEAR_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && cur_prot[1] |-> (wr_value & ~old_data) == '0); // R4

  AST_AUTH_GUARD: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && cur_prot[0] |-> req_op == 2'd2 && mac_ok); // R5

  AST_AUTH_NEEDS_MAC: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && req_op == 2'd2 |-> mac_ok); // R6

  AST_FLAGS_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ($past(prot_flat) & ~prot_flat) == '0); // R7
endmodule

bind blkprot_gate blkprot_chk #(.NUM_BLK(NUM_BLK), .SEG_W(SEG_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .req_valid(req_valid),
  .req_op   (req_op),
  .mac_ok   (mac_ok),
  .rsp_valid(rsp_valid),
  .rsp_code (rsp_code),
  .rsp_data (rsp_data),
  .cur_prot (cur_prot),
  .wr_en    (wr_en),
  .wr_value (wr_value),
  .old_data (old_data),
  .prot_flat(prot_flat)
);

// File: tb/blkprot_gate_tb.sv
module blkprot_gate_tb;
  localparam int SEG_AW = 5;
  localparam int SEG_W  = 32;

  typedef struct packed {
    logic [1:0]  op;
    logic [4:0]  seg;
    logic [31:0] data;
    logic [3:0]  prot;
    logic        mac;
    logic [1:0]  ecode;
    logic [31:0] edata;
    logic [3:0]  req;
  } vec_t;

  // ops: 0 read, 1 write, 2 auth write, 3 flag update
  // flags: 8 hide, 4 freeze, 2 clear-only, 1 needs-auth; codes: 0 ok 1 hidden 2 frozen 3 auth
  localparam int NV = 33;
  localparam vec_t VEC [NV] = '{
    '{2'd0, 5'd0,  32'h0,        4'h0, 1'b0, 2'd0, 32'h0,        4'd8},  // R8 reset data
    '{2'd1, 5'd0,  32'hA5A5A5A5, 4'h0, 1'b0, 2'd0, 32'hA5A5A5A5, 4'd1},  // R1
    '{2'd0, 5'd0,  32'h0,        4'h0, 1'b0, 2'd0, 32'hA5A5A5A5, 4'd1},  // R1
    '{2'd2, 5'd1,  32'h12345678, 4'h0, 1'b1, 2'd0, 32'h12345678, 4'd6},  // R6
    '{2'd2, 5'd1,  32'hFFFFFFFF, 4'h0, 1'b0, 2'd3, 32'h0,        4'd6},  // R6
    '{2'd0, 5'd1,  32'h0,        4'h0, 1'b0, 2'd0, 32'h12345678, 4'd6},  // R6
    '{2'd1, 5'd4,  32'hFFFF00FF, 4'h0, 1'b0, 2'd0, 32'hFFFF00FF, 4'd4},  // R4
    '{2'd3, 5'd4,  32'h0,        4'h2, 1'b0, 2'd0, 32'h2,        4'd7},  // R7
    '{2'd1, 5'd4,  32'h0F0FFFFF, 4'h0, 1'b0, 2'd0, 32'h0F0F00FF, 4'd4},  // R4
    '{2'd0, 5'd4,  32'h0,        4'h0, 1'b0, 2'd0, 32'h0F0F00FF, 4'd4},  // R4
    '{2'd3, 5'd8,  32'h0,        4'h1, 1'b0, 2'd0, 32'h1,        4'd7},  // R7
    '{2'd1, 5'd8,  32'h11111111, 4'h0, 1'b0, 2'd3, 32'h0,        4'd5},  // R5
    '{2'd2, 5'd8,  32'h11111111, 4'h0, 1'b0, 2'd3, 32'h0,        4'd5},  // R5
    '{2'd2, 5'd8,  32'h11111111, 4'h0, 1'b1, 2'd0, 32'h11111111, 4'd5},  // R5
    '{2'd0, 5'd8,  32'h0,        4'h0, 1'b0, 2'd0, 32'h11111111, 4'd5},  // R5
    '{2'd1, 5'd12, 32'hAAAAAAAA, 4'h0, 1'b0, 2'd0, 32'hAAAAAAAA, 4'd9},  // R9
    '{2'd3, 5'd12, 32'h0,        4'h3, 1'b0, 2'd0, 32'h3,        4'd9},  // R9
    '{2'd1, 5'd12, 32'h0,        4'h0, 1'b0, 2'd3, 32'h0,        4'd9},  // R9
    '{2'd2, 5'd12, 32'h0F0F0F0F, 4'h0, 1'b1, 2'd0, 32'h0A0A0A0A, 4'd9},  // R9
    '{2'd0, 5'd12, 32'h0,        4'h0, 1'b0, 2'd0, 32'h0A0A0A0A, 4'd9},  // R9
    '{2'd3, 5'd16, 32'h0,        4'h4, 1'b0, 2'd0, 32'h4,        4'd7},  // R7
    '{2'd1, 5'd16, 32'h1,        4'h0, 1'b0, 2'd2, 32'h0,        4'd3},  // R3
    '{2'd2, 5'd16, 32'h1,        4'h0, 1'b1, 2'd2, 32'h0,        4'd3},  // R3
    '{2'd0, 5'd16, 32'h0,        4'h0, 1'b0, 2'd0, 32'h0,        4'd3},  // R3
    '{2'd1, 5'd20, 32'hCAFEBABE, 4'h0, 1'b0, 2'd0, 32'hCAFEBABE, 4'd1},  // R1
    '{2'd3, 5'd20, 32'h0,        4'h8, 1'b0, 2'd0, 32'h8,        4'd7},  // R7
    '{2'd0, 5'd20, 32'h0,        4'h0, 1'b0, 2'd1, 32'h0,        4'd2},  // R2
    '{2'd3, 5'd20, 32'h0,        4'h0, 1'b0, 2'd0, 32'h8,        4'd7},  // R7 sticky
    '{2'd3, 5'd21, 32'h0,        4'h4, 1'b0, 2'd0, 32'hC,        4'd7},  // R7
    '{2'd3, 5'd8,  32'h0,        4'h4, 1'b0, 2'd0, 32'h5,        4'd7},  // R7
    '{2'd2, 5'd8,  32'h22222222, 4'h0, 1'b1, 2'd2, 32'h0,        4'd3},  // R3 over auth
    '{2'd1, 5'd3,  32'hDEADBEEF, 4'h0, 1'b0, 2'd0, 32'hDEADBEEF, 4'd10}, // R10
    '{2'd1, 5'd7,  32'h00000005, 4'h0, 1'b0, 2'd0, 32'h0,        4'd10}  // R10
  };

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              req_valid = 1'b0;
  logic [1:0]        req_op = '0;
  logic [SEG_AW-1:0] req_seg = '0;
  logic [SEG_W-1:0]  req_data = '0;
  logic [3:0]        req_prot = '0;
  logic              mac_ok = 1'b0;
  logic [SEG_AW-1:0] int_seg = '0;
  logic [SEG_W-1:0]  int_data;
  logic              rsp_valid;
  logic [1:0]        rsp_code;
  logic [SEG_W-1:0]  rsp_data;

  int checks = 0;
  int fails  = 0;

  always #2.5 clk = ~clk;

  blkprot_gate u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
    .req_seg(req_seg), .req_data(req_data), .req_prot(req_prot), .mac_ok(mac_ok),
    .int_seg(int_seg), .int_data(int_data), .rsp_valid(rsp_valid),
    .rsp_code(rsp_code), .rsp_data(rsp_data)
  );

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic issue(input vec_t v);
    @(negedge clk);
    req_valid = 1'b1; req_op = v.op; req_seg = v.seg; req_data = v.data;
    req_prot = v.prot; mac_ok = v.mac;
    @(negedge clk);
    req_valid = 1'b0; mac_ok = 1'b0;
    check($sformatf("R%0d vec", v.req), {31'd0, rsp_valid, rsp_code, rsp_data},
          {31'd0, 1'b1, v.ecode, v.edata});
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R8 rsp_valid in reset", {63'd0, rsp_valid}, 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R8 idle after reset", {63'd0, rsp_valid}, 64'd0);
    for (int i = 0; i < NV; i++) issue(VEC[i]);
    // R2: hidden segment 20 still visible internally
    int_seg = 5'd20;
    @(negedge clk);
    check("R2 internal port", {32'd0, int_data}, {32'd0, 32'hCAFEBABE});
    // R3: frozen segment 16 unchanged, seen internally too
    int_seg = 5'd16;
    @(negedge clk);
    check("R3 frozen data", {32'd0, int_data}, 64'd0);
    // R1: no response without a request
    @(negedge clk);
    check("R1 no request", {63'd0, rsp_valid}, 64'd0);
    // R8: reset again clears data and flags
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    issue('{2'd0, 5'd4, 32'h0, 4'h0, 1'b0, 2'd0, 32'h0, 4'd8});
    issue('{2'd3, 5'd20, 32'h0, 4'h0, 1'b0, 2'd0, 32'h0, 4'd8});
    finish_run();
  end
endmodule